// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the finite-state controller of a 32-bit load/store processor that shares one memory between instructions and data and has a single ALU. Each instruction is broken into single-cycle steps. Every class first passes through a common fetch step and a common decode step, then takes its own short tail before control comes back to fetch. In fetch, the ALU forms PC+4. In decode, the otherwise idle ALU forms the branch target (PC plus the sign-extended, word-scaled immediate) into the ALU output register, so that a branch can resolve one step later.

The controller reads the 6-bit opcode and 6-bit function field from the instruction register, and the ALU zero flag. In each state it drives plain control pins into the datapath. These are the memory strobes, the address select, the instruction-register load, the PC enables with a combined PC load strobe, the ALU operand selects, the ALU operation class and the resolved 4-bit ALU command, the register-file write with its destination and data selects, and the PC source select. No data stream passes through the block, so it has no valid/ready handshake. Every pin is a level that is valid for the whole cycle in which the state is held.

Reset is synchronous and active high, and it forces the fetch state.

Top module: `mcc_ctrl`

## Requirements
- R1: While `rst_i` is high at a rising edge, the next state is fetch; the cycle after a reset edge shows the fetch controls.
- R2: In fetch, the block asserts `mem_rd_o`, `ir_we_o`, `pc_we_o` and `pc_load_o`, with `alu_b_sel_o`=01 (constant 4), `alu_a_sel_o`=0 (PC), `addr_sel_o`=0 (PC) and `pc_src_sel_o`=00 (ALU result).
- R3: Fetch is always followed by decode. Decode drives only `alu_b_sel_o`=11 (shifted immediate), with `alu_a_sel_o`=0 and the add class.
- R4: Opcode 6'h23 (load) runs five cycles. After fetch and decode comes the address step (`alu_a_sel_o`=1, `alu_b_sel_o`=10). Next is the read step (`mem_rd_o`=1, `addr_sel_o`=1). Last is the write-back step (`reg_we_o`=1, `reg_data_sel_o`=1 memory data, `reg_dst_sel_o`=0 rt).
- R5: Opcode 6'h2B (store) runs four cycles: fetch, decode, the address step, then `mem_wr_o`=1 with `addr_sel_o`=1.
- R6: Opcode 6'h00 (R-type) runs four cycles. After fetch and decode comes the execute step (`alu_a_sel_o`=1, `alu_b_sel_o`=00, class function), then write-back (`reg_we_o`=1, `reg_dst_sel_o`=1 rd, `reg_data_sel_o`=0).
- R7: Opcode 6'h04 (branch-if-equal) runs three cycles. Its last step drives `alu_a_sel_o`=1, `alu_b_sel_o`=00, the subtract class, `pc_cond_we_o`=1 and `pc_src_sel_o`=01. In that step `pc_load_o` equals `zero_i`.
- R8: Opcode 6'h02 (jump) runs three cycles. Its last step drives `pc_we_o`=1, `pc_load_o`=1 and `pc_src_sel_o`=10.
- R9: `alu_ctrl_o` is 0010 for the add class and 0110 for the subtract class. For the function class it follows the function field: 6'h20→0010, 6'h22→0110, 6'h24→0000, 6'h25→0001, 6'h2A→0111, and any other value→0010.
- R10: Any other opcode returns to fetch straight after decode, so it takes two cycles.
- R11: `mem_rd_o` and `mem_wr_o` are never high together, and neither are `pc_we_o` and `pc_cond_we_o`. A control not listed for a state is 0, and the class is add (`alu_class_o`=00; 01 subtract, 10 function).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| opcode_i | input | 6 | Opcode field of the instruction register |
| funct_i | input | 6 | Function field of the instruction register |
| zero_i | input | 1 | ALU zero flag |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| addr_sel_o | output | 1 | Memory address: 0 PC, 1 ALU output register |
| ir_we_o | output | 1 | Instruction register load |
| pc_we_o | output | 1 | Unconditional PC write |
| pc_cond_we_o | output | 1 | PC write qualified by zero |
| pc_load_o | output | 1 | Resolved PC load strobe |
| alu_a_sel_o | output | 1 | ALU A: 0 PC, 1 register A |
| alu_b_sel_o | output | 2 | ALU B: 00 reg B, 01 four, 10 immediate, 11 immediate<<2 |
| alu_class_o | output | 2 | Operation class: 00 add, 01 subtract, 10 function |
| alu_ctrl_o | output | 4 | Resolved ALU command |
| reg_we_o | output | 1 | Register file write |
| reg_dst_sel_o | output | 1 | Destination: 0 rt, 1 rd |
| reg_data_sel_o | output | 1 | Write data: 0 ALU output, 1 memory data |
| pc_src_sel_o | output | 2 | PC source: 00 ALU, 01 ALU output register, 10 jump target |

## Verification
All outputs are decoded from the state register. Each one therefore belongs to the cycle that follows the rising edge on which the state was entered. `pc_load_o` also follows `zero_i` within that same cycle. The bench sets the opcode, function and zero inputs at the falling edge that opens an instruction's fetch cycle. At that moment it queues the expected control word for every cycle of that instruction's class, and the monitor compares one entry shortly after each later falling edge, well clear of the next rising edge. Reset is covered both from power-up and when reset arrives in the middle of a load, where fetch is due one edge after reset is sampled.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int OPC_W  = 6;
  localparam int FN_W   = 6;
  localparam int ACTL_W = 4;

  localparam logic [OPC_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OP_STORE = 6'h2B;
  localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OP_JUMP  = 6'h02;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  localparam logic [ACTL_W-1:0] ACMD_AND = 4'b0000;
  localparam logic [ACTL_W-1:0] ACMD_OR  = 4'b0001;
  localparam logic [ACTL_W-1:0] ACMD_ADD = 4'b0010;
  localparam logic [ACTL_W-1:0] ACMD_SUB = 4'b0110;
  localparam logic [ACTL_W-1:0] ACMD_SLT = 4'b0111;

  typedef enum logic [1:0] {
    CLS_ADD  = 2'b00,
    CLS_SUB  = 2'b01,
    CLS_FUNC = 2'b10
  } alu_cls_e;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_ADDR,
    ST_RDMEM,
    ST_LDWB,
    ST_WRMEM,
    ST_EXEC,
    ST_RWB,
    ST_BRANCH,
    ST_JUMP
  } state_e;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       ir_we;
    logic       pc_we;
    logic       pc_cond_we;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    alu_cls_e   alu_cls;
    logic       reg_we;
    logic       reg_dst_sel;
    logic       reg_data_sel;
    logic [1:0] pc_src_sel;
  } ctl_t;
endpackage

// File: rtl/mcc_seq.sv
module mcc_seq
  import mcc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [OPC_W-1:0] opcode_i,
  output state_e           state_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = ST_FETCH;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        if (opcode_i == OP_LOAD || opcode_i == OP_STORE) state_d = ST_ADDR;
        else if (opcode_i == OP_RTYPE)                   state_d = ST_EXEC;
        else if (opcode_i == OP_BEQ)                     state_d = ST_BRANCH;
        else if (opcode_i == OP_JUMP)                    state_d = ST_JUMP;
        else                                             state_d = ST_FETCH;
      end
      ST_ADDR:   state_d = (opcode_i == OP_LOAD) ? ST_RDMEM : ST_WRMEM;
      ST_RDMEM:  state_d = ST_LDWB;
      ST_EXEC:   state_d = ST_RWB;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) state_q <= ST_FETCH;
    else       state_q <= state_d;
  end

  assign state_o = state_q;

  // R1: a reset edge lands in fetch
  a_r1_reset_to_fetch: assert property (@(posedge clk_i)
    rst_i |=> state_q == ST_FETCH);
  // R3: fetch always hands over to decode
  a_r3_fetch_then_decode: assert property (@(posedge clk_i) disable iff (rst_i)
    state_q == ST_FETCH |=> state_q == ST_DECODE);
  // R10: an unlisted opcode goes back to fetch after decode
  a_r10_unknown_back: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_DECODE && opcode_i != OP_RTYPE && opcode_i != OP_LOAD &&
     opcode_i != OP_STORE && opcode_i != OP_BEQ && opcode_i != OP_JUMP)
    |=> state_q == ST_FETCH);
endmodule

// File: rtl/mcc_out_dec.sv
module mcc_out_dec
  import mcc_pkg::*;
(
  input  state_e state_i,
  output ctl_t   ctl_o
);
  always_comb begin
    ctl_o = '0;
    ctl_o.alu_cls = CLS_ADD;
    unique case (state_i)
      ST_FETCH: begin
        ctl_o.mem_rd    = 1'b1;
        ctl_o.ir_we     = 1'b1;
        ctl_o.pc_we     = 1'b1;
        ctl_o.alu_b_sel = 2'b01;
      end
      ST_DECODE: ctl_o.alu_b_sel = 2'b11;
      ST_ADDR: begin
        ctl_o.alu_a_sel = 1'b1;
        ctl_o.alu_b_sel = 2'b10;
      end
      ST_RDMEM: begin
        ctl_o.mem_rd   = 1'b1;
        ctl_o.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctl_o.reg_we       = 1'b1;
        ctl_o.reg_data_sel = 1'b1;
      end
      ST_WRMEM: begin
        ctl_o.mem_wr   = 1'b1;
        ctl_o.addr_sel = 1'b1;
      end
      ST_EXEC: begin
        ctl_o.alu_a_sel = 1'b1;
        ctl_o.alu_cls   = CLS_FUNC;
      end
      ST_RWB: begin
        ctl_o.reg_we      = 1'b1;
        ctl_o.reg_dst_sel = 1'b1;
      end
      ST_BRANCH: begin
        ctl_o.alu_a_sel  = 1'b1;
        ctl_o.alu_cls    = CLS_SUB;
        ctl_o.pc_cond_we = 1'b1;
        ctl_o.pc_src_sel = 2'b01;
      end
      ST_JUMP: begin
        ctl_o.pc_we      = 1'b1;
        ctl_o.pc_src_sel = 2'b10;
      end
      default: ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/mcc_alu_dec.sv
module mcc_alu_dec
  import mcc_pkg::*;
(
  input  alu_cls_e          cls_i,
  input  logic [FN_W-1:0]   funct_i,
  output logic [ACTL_W-1:0] cmd_o
);
  logic [ACTL_W-1:0] fn_cmd;

  always_comb begin
    unique case (funct_i)
      FN_ADD:  fn_cmd = ACMD_ADD;
      FN_SUB:  fn_cmd = ACMD_SUB;
      FN_AND:  fn_cmd = ACMD_AND;
      FN_OR:   fn_cmd = ACMD_OR;
      FN_SLT:  fn_cmd = ACMD_SLT;
      default: fn_cmd = ACMD_ADD;
    endcase
  end

  always_comb begin
    unique case (cls_i)
      CLS_SUB:  cmd_o = ACMD_SUB;
      CLS_FUNC: cmd_o = fn_cmd;
      default:  cmd_o = ACMD_ADD;
    endcase
  end
endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
  import mcc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic [5:0]  opcode_i,
  input  logic [5:0]  funct_i,
  input  logic        zero_i,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic        addr_sel_o,
  output logic        ir_we_o,
  output logic        pc_we_o,
  output logic        pc_cond_we_o,
  output logic        pc_load_o,
  output logic        alu_a_sel_o,
  output logic [1:0]  alu_b_sel_o,
  output logic [1:0]  alu_class_o,
  output logic [3:0]  alu_ctrl_o,
  output logic        reg_we_o,
  output logic        reg_dst_sel_o,
  output logic        reg_data_sel_o,
  output logic [1:0]  pc_src_sel_o
);
  state_e state;
  ctl_t   ctl;

  mcc_seq u_seq (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .opcode_i (opcode_i),
    .state_o  (state)
  );

  mcc_out_dec u_out (
    .state_i (state),
    .ctl_o   (ctl)
  );

  mcc_alu_dec u_alu (
    .cls_i   (ctl.alu_cls),
    .funct_i (funct_i),
    .cmd_o   (alu_ctrl_o)
  );

  assign mem_rd_o       = ctl.mem_rd;
  assign mem_wr_o       = ctl.mem_wr;
  assign addr_sel_o     = ctl.addr_sel;
  assign ir_we_o        = ctl.ir_we;
  assign pc_we_o        = ctl.pc_we;
  assign pc_cond_we_o   = ctl.pc_cond_we;
  assign pc_load_o      = ctl.pc_we | (ctl.pc_cond_we & zero_i);
  assign alu_a_sel_o    = ctl.alu_a_sel;
  assign alu_b_sel_o    = ctl.alu_b_sel;
  assign alu_class_o    = ctl.alu_cls;
  assign reg_we_o       = ctl.reg_we;
  assign reg_dst_sel_o  = ctl.reg_dst_sel;
  assign reg_data_sel_o = ctl.reg_data_sel;
  assign pc_src_sel_o   = ctl.pc_src_sel;

  // R1: one edge after reset the fetch controls show
  a_r1_reset_fetch_pins: assert property (@(posedge clk_i)
    rst_i |=> (ir_we_o && mem_rd_o && pc_we_o));
  // R2: the instruction load always reads memory at the PC
  a_r2_fetch_reads_pc: assert property (@(posedge clk_i) disable iff (rst_i)
    ir_we_o |-> (mem_rd_o && !addr_sel_o && alu_b_sel_o == 2'b01));
  // R4 / R6: a register write completes the instruction
  a_r4_wb_completes: assert property (@(posedge clk_i) disable iff (rst_i)
    reg_we_o |=> ir_we_o);
  // R5: a memory write completes the store
  a_r5_store_completes: assert property (@(posedge clk_i) disable iff (rst_i)
    mem_wr_o |=> ir_we_o);
  // R7: the conditional PC write sees a subtract command
  a_r7_branch_subtracts: assert property (@(posedge clk_i) disable iff (rst_i)
    pc_cond_we_o |-> (alu_ctrl_o == ACMD_SUB && pc_load_o == zero_i));
  // R8: a jump completes in its own step
  a_r8_jump_completes: assert property (@(posedge clk_i) disable iff (rst_i)
    (pc_we_o && pc_src_sel_o == 2'b10) |=> ir_we_o);
  // R11: exclusive memory strobes and PC enables
  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
    !(mem_rd_o && mem_wr_o) && $onehot0({pc_we_o, pc_cond_we_o}));
endmodule

// File: tb/mcc_ctrl_tb_top.sv
module mcc_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic [5:0] opcode_i = 6'h00;
  logic [5:0] funct_i = 6'h00;
  logic       zero_i = 1'b0;
  logic       mem_rd_o, mem_wr_o, addr_sel_o, ir_we_o, pc_we_o, pc_cond_we_o, pc_load_o;
  logic       alu_a_sel_o, reg_we_o, reg_dst_sel_o, reg_data_sel_o;
  logic [1:0] alu_b_sel_o, alu_class_o, pc_src_sel_o;
  logic [3:0] alu_ctrl_o;

  always #2.5 clk_i = ~clk_i;

  mcc_ctrl dut_i (
    .clk_i(clk_i), .rst_i(rst_i), .opcode_i(opcode_i), .funct_i(funct_i), .zero_i(zero_i),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .addr_sel_o(addr_sel_o), .ir_we_o(ir_we_o),
    .pc_we_o(pc_we_o), .pc_cond_we_o(pc_cond_we_o), .pc_load_o(pc_load_o),
    .alu_a_sel_o(alu_a_sel_o), .alu_b_sel_o(alu_b_sel_o), .alu_class_o(alu_class_o),
    .alu_ctrl_o(alu_ctrl_o), .reg_we_o(reg_we_o), .reg_dst_sel_o(reg_dst_sel_o),
    .reg_data_sel_o(reg_data_sel_o), .pc_src_sel_o(pc_src_sel_o)
  );

  typedef struct {
    logic [20:0] v;
    string       tag;
  } item_t;

  item_t queue_q[$];
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  localparam int S_F = 0, S_D = 1, S_A = 2, S_MR = 3, S_LW = 4, S_MW = 5,
                 S_EX = 6, S_RW = 7, S_BR = 8, S_J = 9;

  function automatic logic [3:0] fn_cmd(input logic [5:0] fn);
    case (fn)
      6'h20: return 4'b0010;
      6'h22: return 4'b0110;
      6'h24: return 4'b0000;
      6'h25: return 4'b0001;
      6'h2A: return 4'b0111;
      default: return 4'b0010;
    endcase
  endfunction

  // {mem_rd, mem_wr, addr, ir_we, pc_we, pc_cond, pc_load, a_sel, b_sel[2], cls[2], ctrl[4], reg_we, dst, data, pc_src[2]}
  function automatic logic [20:0] exp_vec(input int st, input logic [5:0] fn, input logic z);
    logic rd = 0, wr = 0, ad = 0, ir = 0, pw = 0, pc = 0, pl = 0, as = 0, rw = 0, ds = 0, dt = 0;
    logic [1:0] bs = 2'b00, cl = 2'b00, ps = 2'b00;
    logic [3:0] ct = 4'b0010;
    case (st)
      S_F:  begin rd = 1; ir = 1; pw = 1; pl = 1; bs = 2'b01; end
      S_D:  bs = 2'b11;
      S_A:  begin as = 1; bs = 2'b10; end
      S_MR: begin rd = 1; ad = 1; end
      S_LW: begin rw = 1; dt = 1; end
      S_MW: begin wr = 1; ad = 1; end
      S_EX: begin as = 1; cl = 2'b10; ct = fn_cmd(fn); end
      S_RW: begin rw = 1; ds = 1; end
      S_BR: begin as = 1; cl = 2'b01; ct = 4'b0110; pc = 1; pl = z; ps = 2'b01; end
      S_J:  begin pw = 1; pl = 1; ps = 2'b10; end
      default: ;
    endcase
    return {rd, wr, ad, ir, pw, pc, pl, as, bs, cl, ct, rw, ds, dt, ps};
  endfunction

  function automatic logic [20:0] act_vec();
    return {mem_rd_o, mem_wr_o, addr_sel_o, ir_we_o, pc_we_o, pc_cond_we_o, pc_load_o,
            alu_a_sel_o, alu_b_sel_o, alu_class_o, alu_ctrl_o, reg_we_o, reg_dst_sel_o,
            reg_data_sel_o, pc_src_sel_o};
  endfunction

  task automatic push(input int st, input logic [5:0] fn, input logic z, input string tag);
    item_t it;
    it.v = exp_vec(st, fn, z);
    it.tag = tag;
    queue_q.push_back(it);
  endtask

  // Called at a falling edge inside a fetch cycle; returns at the next fetch cycle.
  task automatic run(input logic [5:0] op, input logic [5:0] fn, input logic z, input string tag);
    int n;
    opcode_i = op; funct_i = fn; zero_i = z;
    push(S_F, fn, z, "R2");
    push(S_D, fn, z, "R3");
    case (op)
      6'h23: begin push(S_A, fn, z, tag); push(S_MR, fn, z, tag); push(S_LW, fn, z, tag); n = 5; end
      6'h2B: begin push(S_A, fn, z, tag); push(S_MW, fn, z, tag); n = 4; end
      6'h00: begin push(S_EX, fn, z, tag); push(S_RW, fn, z, tag); n = 4; end
      6'h04: begin push(S_BR, fn, z, tag); n = 3; end
      6'h02: begin push(S_J, fn, z, tag); n = 3; end
      default: n = 2;
    endcase
    repeat (n) @(negedge clk_i);
  endtask

  // Monitor: compare one queued word shortly after every falling edge.
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (queue_q.size() > 0) begin
        item_t it;
        it = queue_q.pop_front();
        n_run++;
        if (act_vec() !== it.v) begin
          n_fail++;
          $display("FAIL %s: actual=%b expected=%b", it.tag, act_vec(), it.v);
        end
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    push(S_F, 6'h00, 1'b0, "R1");
    @(negedge clk_i);
    rst_i = 1'b0;
    run(6'h23, 6'h00, 1'b0, "R4");
    run(6'h2B, 6'h00, 1'b0, "R5");
    run(6'h00, 6'h20, 1'b0, "R6");
    run(6'h00, 6'h22, 1'b0, "R9");
    run(6'h00, 6'h24, 1'b1, "R9");
    run(6'h00, 6'h25, 1'b0, "R9");
    run(6'h00, 6'h2A, 1'b0, "R9");
    run(6'h00, 6'h3F, 1'b0, "R9");
    run(6'h04, 6'h00, 1'b1, "R7");
    run(6'h04, 6'h22, 1'b0, "R7");
    run(6'h02, 6'h00, 1'b1, "R8");
    run(6'h3F, 6'h00, 1'b0, "R10");
    run(6'h2B, 6'h25, 1'b1, "R11");
    run(6'h05, 6'h00, 1'b1, "R10");
    run(6'h23, 6'h2A, 1'b1, "R11");
    // R1: reset in the middle of a load
    opcode_i = 6'h23;
    push(S_F, 6'h00, 1'b0, "R2");
    push(S_D, 6'h00, 1'b0, "R3");
    @(negedge clk_i);
    rst_i = 1'b1;
    @(negedge clk_i);
    push(S_F, 6'h00, 1'b0, "R1");
    @(negedge clk_i);
    rst_i = 1'b0;
    run(6'h00, 6'h22, 1'b0, "R6");
    @(negedge clk_i);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule